// File: doc/BRIEF.md
# Eight-Pin Bidirectional GPIO Port

This block controls an eight-pin general-purpose I/O port. Each pin has a direction bit, a level bit and a sampled input bit. A small register bus writes and reads the direction and level registers and reads the synchronized pad levels. For every pin the block drives three signals to an external pad model: an output enable, an output value and a pull-up enable.

The level bit has two uses. On an output pin it sets the driven level. On an input pin it turns on the weak pull-up. A shared pull-up-kill input forces every pull-up off, whatever the register bits hold. A shared sleep input clamps the input path to zero. Reset clears the direction and level bits asynchronously, so the pins float even when no clock is running.

Top module: `gpio_port`

## Requirements
- R1: An active-low asynchronous reset (`rst_n`) clears the direction and level registers to 0x00. While reset is low, `pad_oe`, `pad_out` and `pad_pu` are all zero, even with no clock edge.
- R2: For each pin, {dir, lvl} selects the pad state. 00 gives oe=0, out=0, pu=0. 01 gives oe=0, out=0, pu=1. 10 gives oe=1, out=0, pu=0. 11 gives oe=1, out=1, pu=0.
- R3: When `pu_kill` is 1, `pad_pu` is 0x00 for every register setting.
- R4: A write with `wr_en`=1 on a rising clock edge stores `wdata` into the direction register when `addr`=1, or into the level register when `addr`=2. The new value appears on the pad outputs after that edge.
- R5: `rdata` is combinational from `addr`. Address 1 returns the direction register, address 2 returns the level register, and address 3 returns 0x00.
- R6: Address 0 returns the pad levels sampled through a two-flop synchronizer. A pad change is visible after the second rising edge, and it is not visible after only one.
- R7: While `sleep` is 1, the synchronized pin value is held at zero.
- R8: A write to address 0 or address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register select: 0 pin, 1 direction, 2 level |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| pu_kill | input | 1 | Global pull-up disable |
| sleep | input | 1 | Clamps the input path to zero |
| pad_in | input | 8 | Pad levels from the pad model |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin driven level |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The hardest case to reach is the two-edge latency of the synchronizer. It must be observed while an unrelated pad bit moves and while sleep is entered and left. The bench changes `pad_in` just after a falling edge. It then reads the pin address after exactly one rising edge and again after two, and expects the old value and then the new one. The bench also walks every pin through the 00, 01, 11 and 10 encodings, with `pu_kill` both low and high.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   addr,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic         pu_kill,
  input  logic         sleep,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);
  localparam logic [1:0] A_PIN = 2'd0, A_DIR = 2'd1, A_LVL = 2'd2;

  logic [W-1:0] dir_q, lvl_q, meta_q, sync_q;
  logic [W-1:0] gated_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
    end else if (wr_en) begin
      if (addr == A_DIR) dir_q <= wdata;
      if (addr == A_LVL) lvl_q <= wdata;
    end

  assign gated_in = sleep ? '0 : pad_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gated_in;
      sync_q <= sleep ? '0 : meta_q;
    end

  assign pad_oe  = dir_q;
  assign pad_out = dir_q & lvl_q;
  assign pad_pu  = ~dir_q & lvl_q & {W{~pu_kill}};

  always_comb
    case (addr)
      A_PIN:   rdata = sync_q;
      A_DIR:   rdata = dir_q;
      A_LVL:   rdata = lvl_q;
      default: rdata = '0;
    endcase

  assert_reset_tristate_R1: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_pu == '0));
  assert_pu_killed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pu_kill |-> pad_pu == '0);
  assert_no_pu_on_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_DIR) |=> pad_oe == $past(wdata));
  assert_ignored_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_PIN || addr == 2'd3)) |=> ($stable(pad_oe) && $stable(pad_out)));
  assert_sleep_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> sync_q == '0);
endmodule

// File: tb/gpio_port_test.sv
module gpio_port_test;
  logic clk = 0, rst_n = 0, wr_en = 0, pu_kill = 0, sleep = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, pad_in = 0;
  logic [7:0] rdata, pad_oe, pad_out, pad_pu;
  int checks = 0, errors = 0;
  bit done = 0;

  gpio_port uut (.clk, .rst_n, .addr, .wr_en, .wdata, .rdata, .pu_kill, .sleep,
                 .pad_in, .pad_oe, .pad_out, .pad_pu);

  always #4 clk = ~clk;

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [1:0] a, string req, logic [7:0] exp);
    addr = a; #1; chk(req, rdata, exp);
  endtask

  initial begin
    #50000; checks++; errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors); $finish;
  end

  initial begin
    #3;
    chk("R1 oe", pad_oe, 8'h00); chk("R1 pu", pad_pu, 8'h00); chk("R1 out", pad_out, 8'h00);
    @(negedge clk); rst_n = 1;
    rd(2'd1, "R1 dir", 8'h00); rd(2'd2, "R1 lvl", 8'h00);
    for (int p = 0; p < 8; p++) begin
      logic [1:0] seq [4] = '{2'b00, 2'b01, 2'b11, 2'b10};
      for (int s = 0; s < 4; s++) begin
        for (int k = 0; k < 2; k++) begin
          logic [7:0] d, l;
          d = seq[s][1] ? (8'h1 << p) : 8'h0;
          l = seq[s][0] ? (8'h1 << p) : 8'h0;
          pu_kill = k[0];
          wr(2'd1, d); wr(2'd2, l);
          chk("R2 oe", pad_oe, d);
          chk("R2 out", pad_out, d & l);
          chk(k ? "R3 pu" : "R2 pu", pad_pu, k ? 8'h00 : (~d & l));
          rd(2'd1, "R5 dir", d); rd(2'd2, "R5 lvl", l);
        end
      end
    end
    pu_kill = 0;
    wr(2'd1, 8'hA5); wr(2'd2, 8'h3C);
    chk("R4 oe", pad_oe, 8'hA5); chk("R4 out", pad_out, 8'h24);
    wr(2'd0, 8'hFF); wr(2'd3, 8'h00);
    rd(2'd1, "R8 dir", 8'hA5); rd(2'd2, "R8 lvl", 8'h3C);
    chk("R8 oe", pad_oe, 8'hA5); chk("R8 pu", pad_pu, 8'h18);
    rd(2'd3, "R5 unused", 8'h00);
    pad_in = 8'h5A; addr = 0;
    @(posedge clk); #1; chk("R6 one edge", rdata, 8'h00);
    @(posedge clk); #1; chk("R6 two edges", rdata, 8'h5A);
    @(negedge clk); pad_in = 8'hC3;
    @(posedge clk); #1; chk("R6 one edge", rdata, 8'h5A);
    @(posedge clk); #1; chk("R6 two edges", rdata, 8'hC3);
    @(negedge clk); sleep = 1;
    @(posedge clk); #1; chk("R7 sleep", rdata, 8'h00);
    @(posedge clk); #1; chk("R7 sleep held", rdata, 8'h00);
    @(negedge clk); sleep = 0;
    @(posedge clk); #1; chk("R7 wake one edge", rdata, 8'h00);
    @(posedge clk); #1; chk("R7 wake", rdata, 8'hC3);
    @(negedge clk); rst_n = 0; #1;
    chk("R1 async oe", pad_oe, 8'h00); chk("R1 async pu", pad_pu, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule